// File: doc/BRIEF.md
# Oversampling Serial Receiver with Character Queue

This block turns an asynchronous serial line into a stream of received characters. It follows a shared time base that pulses sixteen times per bit. It confirms each start bit halfway through the bit and then samples every later bit at its centre. Word length and parity come from static configuration inputs. Each finished character is stored together with three error tags: parity, framing and break. The store is a queue of up to sixteen characters, or a single holding slot when queueing is switched off.

Characters leave through a valid/ready read port. `rd_valid` is high while at least one character is stored. `rd_data` and the tags show the oldest character, and they stay stable while `rd_ready` is low. One character is removed on each cycle where `rd_valid` and `rd_ready` are both high; `rd_ready` has no effect while `rd_valid` is low. The line side cannot be stalled. A character that completes while the store is full is dropped and recorded as an overrun.

Sticky error flags are cleared by a status-read strobe. Two interrupt requests are provided:
- a level request, raised when the fill level reaches a selectable threshold;
- an idle request, raised when stored data has sat untouched for four character times.

Top module: `serial_rx_unit`

## Requirements
- R1: A low on the line starts a frame only if the line is still low 8 ticks after the fall is seen. If it is high again at that point, no character is produced.
- R2: Data bits arrive least-significant first. `cfg_wlen` 00/01/10/11 selects 5/6/7/8 data bits. Bits above the word length read as 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. The expected value is one of:
  - the XOR of the data bits when `cfg_par_even`=1;
  - its inverse when `cfg_par_even`=0;
  - the constant `~cfg_par_even` when `cfg_par_stick`=1.

  A mismatch tags the character with a parity error and sets `stat_perr`.
- R4: A stop bit sampled low tags the character with a framing error and sets `stat_ferr`, unless R5 applies.
- R5: A frame whose data, parity bit (if enabled) and stop bit are all 0 is a break. It stores exactly one zero character tagged break only (no parity or framing tag) and sets `stat_brk`. No new frame starts until the line has returned high.
- R6: With `cfg_fifo_en`=1, up to 16 characters are held and read out oldest first. `stat_avail` and `rd_valid` are 1 exactly while a character is stored.
- R7: With `cfg_fifo_en`=0, only one character is held.
- R8: A character completing while the store is full is discarded. The stored characters are kept and `stat_overrun` is set.
- R9: `irq_level` is 1 while the fill level is at least the threshold. With queueing on, `cfg_trig` 00/01/10/11 selects 1/4/8/14. With queueing off, the threshold is 1.
- R10: `irq_timeout` rises once the store is non-empty, queueing is on, and no character has been stored or read for 4 character times. A character time is 16 ticks per frame bit. The request clears when a character is read.
- R11: A one-cycle `fifo_clr` pulse empties the store.
- R12: `stat_overrun`, `stat_perr`, `stat_ferr` and `stat_brk` stay set until a `stat_rd` pulse clears them. `stat_fifo_err` is 1 while any stored character carries an error tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse, 16 per bit time |
| rx_i | input | 1 | Serial line, idle high |
| cfg_wlen | input | 2 | Word length select (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select |
| cfg_par_stick | input | 1 | Constant parity bit |
| cfg_fifo_en | input | 1 | Queue enable (0: single slot) |
| cfg_trig | input | 2 | Level request threshold select |
| fifo_clr | input | 1 | Empty the store |
| rd_valid | output | 1 | A character is available |
| rd_ready | input | 1 | Consumer takes the character |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity tag of oldest character |
| rd_ferr | output | 1 | Framing tag of oldest character |
| rd_brk | output | 1 | Break tag of oldest character |
| stat_avail | output | 1 | Data available |
| stat_overrun | output | 1 | Sticky overrun |
| stat_perr | output | 1 | Sticky parity error |
| stat_ferr | output | 1 | Sticky framing error |
| stat_brk | output | 1 | Sticky break |
| stat_fifo_err | output | 1 | Some stored character is tagged |
| stat_rd | input | 1 | Status-read strobe, clears sticky flags |
| irq_level | output | 1 | Fill-level request |
| irq_timeout | output | 1 | Idle-data request |

## Verification
The assertions assume three things about the inputs:
- `tick16` is a single-cycle pulse;
- the configuration inputs hold still for the whole of a frame;
- `fifo_clr` and `stat_rd` are single-cycle strobes.

The stimulus keeps to these rules. It spaces ticks evenly every four clocks, changes configuration only between frames, and raises each strobe for exactly one cycle between two clock edges. It drives line levels for whole bit times of 64 clocks, so every sample lands well inside a bit. Glitches and held-low breaks are the only deliberate departures from clean frames.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;
  localparam int unsigned MAX_BITS = 8;
  localparam int unsigned BIT_W    = $clog2(MAX_BITS);

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                perr;
    logic                ferr;
    logic                brk;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
  } rx_state_t;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/serial_rx_deframer.sv
`timescale 1ns/1ps
module serial_rx_deframer
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_i,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       out_valid,
  output rx_char_t   out_char
);
  logic [1:0]          sync_q;
  logic                rx_s;
  rx_state_t           st_q;
  logic [3:0]          cnt_q;
  logic [BIT_W-1:0]    bit_q;
  logic [MAX_BITS-1:0] sh_q;
  logic                xacc_q, pbit_q;
  logic                mid, brk_c, exp_par, perr_c, ferr_c;
  logic [BIT_W-1:0]    last_idx;
  rx_char_t            out_q;

  assign rx_s     = sync_q[1];
  assign last_idx = BIT_W'(4) + BIT_W'(wlen);
  assign out_char = out_q;

  always_comb begin
    mid     = tick && (cnt_q == 4'hF);
    brk_c   = (sh_q == '0) && (!par_en || !pbit_q) && !rx_s;
    exp_par = par_stick ? ~par_even : (par_even ? xacc_q : ~xacc_q);
    perr_c  = par_en && (pbit_q != exp_par) && !brk_c;
    ferr_c  = !rx_s && !brk_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      xacc_q    <= 1'b0;
      pbit_q    <= 1'b0;
      out_valid <= 1'b0;
      out_q     <= '0;
    end else begin
      sync_q    <= {sync_q[0], rx_i};
      out_valid <= 1'b0;
      if (tick) cnt_q <= cnt_q + 4'd1;
      case (st_q)
        S_IDLE: if (tick && !rx_s) begin
          st_q  <= S_START;
          cnt_q <= 4'd7;
        end
        S_START: if (mid) begin
          if (rx_s) st_q <= S_IDLE;
          else begin
            st_q   <= S_DATA;
            bit_q  <= '0;
            sh_q   <= '0;
            xacc_q <= 1'b0;
          end
        end
        S_DATA: if (mid) begin
          sh_q[bit_q] <= rx_s;
          xacc_q      <= xacc_q ^ rx_s;
          if (bit_q == last_idx) st_q <= par_en ? S_PAR : S_STOP;
          else bit_q <= bit_q + 1'b1;
        end
        S_PAR: if (mid) begin
          pbit_q <= rx_s;
          st_q   <= S_STOP;
        end
        S_STOP: if (mid) begin
          out_valid  <= 1'b1;
          out_q.data <= sh_q;
          out_q.perr <= perr_c;
          out_q.ferr <= ferr_c;
          out_q.brk  <= brk_c;
          st_q       <= rx_s ? S_IDLE : S_WAITHI;
        end
        S_WAITHI: if (rx_s) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_START && mid && rx_s) |=> (st_q == S_IDLE && !out_valid)); // R1
  AST_BREAK_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_q.brk) |-> (!out_q.ferr && !out_q.perr && out_q.data == '0)); // R5
  AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAITHI && !rx_s) |=> (st_q == S_WAITHI)); // R5
endmodule

// File: rtl/serial_rx_store.sv
`timescale 1ns/1ps
module serial_rx_store
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_req,
  input  rx_char_t                     push_char,
  input  logic                         fifo_en,
  input  logic                         clr,
  input  logic                         pop,
  output rx_char_t                     head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         accepted,
  output logic                         overrun_evt,
  output logic                         err_present
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  rx_char_t        mem_q [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q, err_q, cap;
  logic            full, take, push_err, head_err;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cap         = fifo_en ? CW'(DEPTH) : CW'(1);
    full        = cnt_q >= cap;
    accepted    = push_req && !full && !clr;
    overrun_evt = push_req && full && !clr;
    take        = pop && (cnt_q != '0) && !clr;
    push_err    = push_char.perr | push_char.ferr | push_char.brk;
    head_err    = mem_q[rp_q].perr | mem_q[rp_q].ferr | mem_q[rp_q].brk;
  end

  assign head        = mem_q[rp_q];
  assign count       = cnt_q;
  assign err_present = err_q != '0;

  always_ff @(posedge clk) begin
    if (accepted) mem_q[wp_q] <= push_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      if (accepted) wp_q <= nxt(wp_q);
      if (take)     rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(accepted) - CW'(take);
      err_q <= err_q + CW'(accepted && push_err) - CW'(take && head_err);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R6
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop && !clr) |=> (cnt_q == $past(cnt_q))); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && err_q == '0)); // R11
endmodule

// File: rtl/serial_rx_idle_timer.sv
`timescale 1ns/1ps
module serial_rx_idle_timer
  import serial_rx_pkg::*;
#(
  parameter int unsigned TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       nonempty,
  input  logic       activity,
  input  logic       rd_evt,
  input  logic [1:0] wlen,
  input  logic       par_en,
  output logic       flag
);
  localparam int unsigned MAX_LIM = TO_CHARS * 16 * (MAX_BITS + 3);
  localparam int unsigned TW      = $clog2(MAX_LIM + 1);

  logic [3:0]    frame_bits;
  logic [TW-1:0] lim, cnt_q;

  always_comb begin
    frame_bits = 4'd7 + {2'b00, wlen} + {3'b000, par_en};
    lim        = TW'(32'(TO_CHARS) * 32'd16 * 32'(frame_bits));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (activity || !nonempty || !enable) cnt_q <= '0;
      else if (tick && cnt_q != lim) cnt_q <= cnt_q + 1'b1;
      if (rd_evt || !nonempty) flag <= 1'b0;
      else if (enable && cnt_q == lim) flag <= 1'b1;
    end
  end

  AST_TO_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> nonempty); // R10
endmodule

// File: rtl/serial_rx_unit.sv
`timescale 1ns/1ps
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_i,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_stick,
  input  logic       cfg_fifo_en,
  input  logic [1:0] cfg_trig,
  input  logic       fifo_clr,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       stat_avail,
  output logic       stat_overrun,
  output logic       stat_perr,
  output logic       stat_ferr,
  output logic       stat_brk,
  output logic       stat_fifo_err,
  input  logic       stat_rd,
  output logic       irq_level,
  output logic       irq_timeout
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  rx_char_t      frm_char, head;
  logic          frm_valid, accepted, ovr_evt, err_present, pop;
  logic [CW-1:0] count, lvl;

  serial_rx_deframer u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_i(rx_i),
    .wlen(cfg_wlen), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .par_stick(cfg_par_stick), .out_valid(frm_valid), .out_char(frm_char)
  );

  serial_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_req(frm_valid), .push_char(frm_char),
    .fifo_en(cfg_fifo_en), .clr(fifo_clr), .pop(pop), .head(head),
    .count(count), .accepted(accepted), .overrun_evt(ovr_evt),
    .err_present(err_present)
  );

  serial_rx_idle_timer #(.TO_CHARS(TO_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .enable(cfg_fifo_en),
    .nonempty(rd_valid), .activity(accepted || pop || fifo_clr),
    .rd_evt(pop || fifo_clr), .wlen(cfg_wlen), .par_en(cfg_par_en),
    .flag(irq_timeout)
  );

  always_comb begin
    rd_valid      = count != '0;
    pop           = rd_valid && rd_ready;
    rd_data       = head.data;
    rd_perr       = head.perr;
    rd_ferr       = head.ferr;
    rd_brk        = head.brk;
    stat_avail    = rd_valid;
    stat_fifo_err = err_present;
    lvl           = cfg_fifo_en ? CW'(trig_level(cfg_trig)) : CW'(1);
    irq_level     = rd_valid && (count >= lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_overrun <= 1'b0;
      stat_perr    <= 1'b0;
      stat_ferr    <= 1'b0;
      stat_brk     <= 1'b0;
    end else begin
      stat_overrun <= (stat_overrun && !stat_rd) || ovr_evt;
      stat_perr    <= (stat_perr && !stat_rd) || (accepted && frm_char.perr);
      stat_ferr    <= (stat_ferr && !stat_rd) || (accepted && frm_char.ferr);
      stat_brk     <= (stat_brk && !stat_rd) || (accepted && frm_char.brk);
    end
  end

  AST_OVR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> stat_overrun); // R8
  AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fifo_en && count >= CW'(14)) |-> irq_level); // R9
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !frm_valid) |=> (!stat_perr && !stat_ferr && !stat_brk && !stat_overrun)); // R12
  AST_NONFIFO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && count == CW'(1) && frm_valid && !pop && !fifo_clr) |=> (count == CW'(1))); // R7
endmodule

// File: tb/serial_rx_unit_bench.sv
`timescale 1ns/1ps
module serial_rx_unit_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick16 = 1'b0, rx_i = 1'b1;
  logic [1:0] cfg_wlen = 2'b11, cfg_trig = 2'b00;
  logic cfg_par_en = 0, cfg_par_even = 0, cfg_par_stick = 0, cfg_fifo_en = 1;
  logic fifo_clr = 0, rd_ready = 0, stat_rd = 0;
  logic rd_valid, rd_perr, rd_ferr, rd_brk, stat_avail, stat_overrun;
  logic stat_perr, stat_ferr, stat_brk, stat_fifo_err, irq_level, irq_timeout;
  logic [7:0] rd_data;

  serial_rx_unit u_serial_rx_unit (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_i(rx_i),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_fifo_en(cfg_fifo_en), .cfg_trig(cfg_trig),
    .fifo_clr(fifo_clr), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk), .stat_avail(stat_avail),
    .stat_overrun(stat_overrun), .stat_perr(stat_perr), .stat_ferr(stat_ferr),
    .stat_brk(stat_brk), .stat_fifo_err(stat_fifo_err), .stat_rd(stat_rd),
    .irq_level(irq_level), .irq_timeout(irq_timeout)
  );

  typedef struct { logic [7:0] d; bit pe; bit fe; bit bk; } ent_t;
  ent_t q[$];
  bit m_ovr, m_pe, m_fe, m_bk;
  bit settled = 0;
  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit any_err();
    foreach (q[i]) if (q[i].pe || q[i].fe || q[i].bk) return 1;
    return 0;
  endfunction

  function automatic bit exp_irq();
    int th;
    case (cfg_trig) 2'b00: th = 1; 2'b01: th = 4; 2'b10: th = 8; default: th = 14; endcase
    if (!cfg_fifo_en) th = 1;
    return (q.size() != 0) && (q.size() >= th);
  endfunction

  // reference comparison on every clock while no frame is in flight
  always @(negedge clk) begin
    if (settled && rst_n) begin
      chk("R6", 32'(rd_valid), 32'(q.size() != 0), "rd_valid");
      chk("R6", 32'(stat_avail), 32'(q.size() != 0), "stat_avail");
      if (q.size() != 0) begin
        chk("R6", 32'(rd_data), 32'(q[0].d), "rd_data");
        chk("R3", 32'(rd_perr), 32'(q[0].pe), "rd_perr");
        chk("R4", 32'(rd_ferr), 32'(q[0].fe), "rd_ferr");
        chk("R5", 32'(rd_brk), 32'(q[0].bk), "rd_brk");
      end
      chk("R8", 32'(stat_overrun), 32'(m_ovr), "stat_overrun");
      chk("R12", 32'(stat_perr), 32'(m_pe), "stat_perr");
      chk("R12", 32'(stat_ferr), 32'(m_fe), "stat_ferr");
      chk("R12", 32'(stat_brk), 32'(m_bk), "stat_brk");
      chk("R12", 32'(stat_fifo_err), 32'(any_err()), "stat_fifo_err");
      chk("R9", 32'(irq_level), 32'(exp_irq()), "irq_level");
    end
  end

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick16 = (div == 3);
      div = (div + 1) % 4;
    end
  end

  task automatic bit_time(input logic v);
    rx_i = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v);
    int nb = 5 + int'(cfg_wlen);
    logic [7:0] mask = 8'hFF >> (3 - int'(cfg_wlen));
    logic [7:0] dm = d & mask;
    logic p;
    bit bk, pe, fe;
    settled = 0;
    p = cfg_par_stick ? ~cfg_par_even : (cfg_par_even ? ^dm : ~^dm);
    p = p ^ bad_par;
    bit_time(1'b0);
    for (int i = 0; i < nb; i++) bit_time(dm[i]);
    if (cfg_par_en) bit_time(p);
    bit_time(stop_v);
    if (!stop_v) begin
      rx_i = 1'b0;
      repeat (128) @(negedge clk);
      rx_i = 1'b1;
    end
    repeat (10) @(negedge clk);
    bk = (dm == 0) && (!cfg_par_en || p == 0) && !stop_v;
    pe = !bk && cfg_par_en && bad_par;
    fe = !bk && !stop_v;
    if (q.size() >= (cfg_fifo_en ? 16 : 1)) m_ovr = 1;
    else begin
      q.push_back('{d: dm, pe: pe, fe: fe, bk: bk});
      m_pe |= pe; m_fe |= fe; m_bk |= bk;
    end
    settled = 1;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, 32'(rd_valid), 32'd1, "valid before read");
    chk(req, 32'(rd_data), 32'(exp), "read data");
    rd_ready = 1;
    @(posedge clk); #1;
    rd_ready = 0;
    void'(q.pop_front());
  endtask

  task automatic status_read();
    @(negedge clk); stat_rd = 1;
    @(posedge clk); #1; stat_rd = 0;
    m_ovr = 0; m_pe = 0; m_fe = 0; m_bk = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6", 32'(rd_valid), 0, "reset rd_valid");
    chk("R9", 32'(irq_level | irq_timeout), 0, "reset irq");
    settled = 1;

    // R2: 8 data bits, LSB first
    send(8'h4F, 0, 1); send(8'h4B, 0, 1);
    pop_chk("R2", 8'h4F); pop_chk("R2", 8'h4B);
    // R2: 5-bit word, upper bits zero
    cfg_wlen = 2'b00; send(8'hF5, 0, 1); pop_chk("R2", 8'h15);

    // R3: parity variants, 7-bit words
    cfg_wlen = 2'b10; cfg_par_en = 1; cfg_par_even = 1;
    send(8'h41, 0, 1); send(8'h41, 1, 1);
    @(negedge clk); chk("R12", 32'(stat_fifo_err), 1, "tagged entry stored");
    pop_chk("R3", 8'h41);
    @(negedge clk); chk("R3", 32'(rd_perr), 1, "bad even parity tag");
    pop_chk("R3", 8'h41);
    @(negedge clk); chk("R3", 32'(stat_perr), 1, "sticky parity");
    status_read();
    @(negedge clk); chk("R12", 32'(stat_perr), 0, "status read clears");
    cfg_par_even = 0; send(8'h03, 0, 1);
    @(negedge clk); chk("R3", 32'(rd_perr), 0, "good odd parity");
    pop_chk("R3", 8'h03);
    cfg_par_stick = 1; send(8'h22, 1, 1);
    @(negedge clk); chk("R3", 32'(rd_perr), 1, "stick parity mismatch");
    pop_chk("R3", 8'h22);
    status_read();
    cfg_par_stick = 0; cfg_par_en = 0; cfg_wlen = 2'b11;

    // R4: framing
    send(8'h55, 0, 0);
    @(negedge clk); chk("R4", 32'(rd_ferr), 1, "low stop bit");
    chk("R4", 32'(rd_brk), 0, "not a break");
    pop_chk("R4", 8'h55);
    status_read();

    // R5: break
    send(8'h00, 0, 0);
    @(negedge clk); chk("R5", 32'(rd_brk), 1, "break tag");
    chk("R5", 32'(q.size()), 1, "single break char");
    pop_chk("R5", 8'h00);
    @(negedge clk); chk("R5", 32'(rd_valid), 0, "no second char after break");
    status_read();

    // R1: glitch
    settled = 0; rx_i = 0; repeat (12) @(negedge clk); rx_i = 1;
    repeat (800) @(negedge clk); settled = 1;
    @(negedge clk); chk("R1", 32'(rd_valid), 0, "glitch ignored");

    // R9: threshold 4
    cfg_trig = 2'b01;
    send(8'h01, 0, 1); send(8'h02, 0, 1); send(8'h03, 0, 1);
    @(negedge clk); chk("R9", 32'(irq_level), 0, "below threshold");
    send(8'h04, 0, 1);
    @(negedge clk); chk("R9", 32'(irq_level), 1, "at threshold");
    for (int i = 1; i <= 4; i++) pop_chk("R6", 8'(i));

    // R10: idle timeout
    cfg_trig = 2'b11;
    send(8'h77, 0, 1);
    repeat (2000) @(negedge clk);
    chk("R10", 32'(irq_timeout), 0, "before 4 char times");
    repeat (800) @(negedge clk);
    chk("R10", 32'(irq_timeout), 1, "after 4 char times");
    pop_chk("R10", 8'h77);
    @(negedge clk); chk("R10", 32'(irq_timeout), 0, "cleared by read");

    // R11: clear
    send(8'h10, 0, 1); send(8'h20, 0, 1);
    @(negedge clk); fifo_clr = 1;
    @(posedge clk); #1; fifo_clr = 0; q.delete();
    @(negedge clk); chk("R11", 32'(rd_valid), 0, "cleared store");

    // R6, R8: fill, overrun
    cfg_trig = 2'b10;
    for (int i = 0; i < 16; i++) send(8'(i * 7 + 3), 0, 1);
    send(8'hEE, 0, 1);
    @(negedge clk); chk("R8", 32'(stat_overrun), 1, "overrun flag");
    chk("R8", 32'(q.size()), 16, "model depth");
    for (int i = 0; i < 16; i++) pop_chk("R6", 8'(i * 7 + 3));
    @(negedge clk); chk("R8", 32'(rd_valid), 0, "dropped char absent");
    status_read();

    // R7: single slot
    cfg_fifo_en = 0;
    send(8'hA1, 0, 1); send(8'hB2, 0, 1);
    @(negedge clk); chk("R7", 32'(stat_overrun), 1, "second char overruns");
    pop_chk("R7", 8'hA1);
    @(negedge clk); chk("R7", 32'(rd_valid), 0, "only one held");
    status_read();

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule